// File: doc/BRIEF.md
# Multicast Flush Scanner

The block walks a lookup table in the background and removes a set of ports from multicast address entries. A one-cycle start pulse brings in a port mask and a VLAN filter. The filter is either one VLAN id or a wildcard that matches every VLAN. The scanner reads each table row in turn and decides whether the row qualifies. A qualifying row loses the flushed ports from its membership. If no member port remains, the row is released. Rows that change are written back to the same index. Rows that do not change are never written. A one-cycle completion pulse follows the last row.

The table itself lives outside the block, behind a simple port. A read returns its row one cycle after the request. A write takes an index and a full row. The scanner owns both ports while it is busy.

The state machine has four states:
- `S_IDLE`: waits for a start pulse, then latches the parameters and moves to `S_READ` at index 0.
- `S_READ`: drives a read of the current index and moves to `S_CHECK`.
- `S_CHECK`: judges the returned row and writes it back if it changes. It then goes to `S_READ` at the next index, or to `S_FIN` after the last index.
- `S_FIN`: raises the completion pulse and returns to `S_IDLE`.

Top module: `mcast_flush`

## Requirements
- R1: After reset, `done_o`, `busy_o`, `tbl_rd_en_o` and `tbl_wr_en_o` are all low.
- R2: After a start, the scanner reads every index from 0 to DEPTH-1 exactly once, in ascending order, two cycles per row. `done_o` is high for exactly one cycle, 2*DEPTH+1 cycles after the edge that captures start. `busy_o` is low again after that cycle.
- R3: Only rows whose type field (bits 61:60) is 1 (address) or 3 (VLAN address) can change. Rows of type 0 and type 2 are left untouched.
- R4: When `all_vlan_i` is low, a row whose VLAN field (bits 59:48) differs from `vid_i` is left untouched. When `all_vlan_i` is high, the VLAN field is not compared.
- R5: A row whose multicast bit (bit 40) is clear is left untouched.
- R6: A row whose super bit (bit 65) is set is left untouched.
- R7: A row whose address field (bits 47:0) is all ones is left untouched.
- R8: A row whose member mask (bits 66 and up, PORTS wide) shares no bit with the flush mask is neither written nor changed.
- R9: In a qualifying row, the flushed ports are cleared from the member mask. If other members remain, the row is written back to its own index with only the mask changed.
- R10: If a qualifying row's mask becomes empty, it is written back with type 0 and a zero mask. All other fields are kept.
- R11: A start pulse that arrives while a scan is running is ignored. The scan is not restarted, its parameters are kept, and only one completion pulse is produced.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | One-cycle request to begin a scan |
| flush_mask_i | input | PORTS | Ports to remove, sampled with start |
| vid_i | input | 12 | VLAN id filter, sampled with start |
| all_vlan_i | input | 1 | Wildcard VLAN filter, sampled with start |
| tbl_rd_en_o | output | 1 | Table read request |
| tbl_addr_o | output | AW | Table index for read and write |
| tbl_rd_data_i | input | 66+PORTS | Row returned one cycle after a read |
| tbl_wr_en_o | output | 1 | Table write strobe |
| tbl_wr_data_o | output | 66+PORTS | Row to write |
| busy_o | output | 1 | Scan in progress |
| done_o | output | 1 | One-cycle completion pulse |

## Verification
Two events can fall in the same cycle: a host start request and the scanner's own activity on a row, including the write-back of the final row just before the completion pulse.

To provoke this, the bench raises a second start with a different mask and VLAN filter in the middle of a scan. It then checks three things:
- The final table matches the parameters of the first start only.
- Exactly one completion pulse occurs.
- That pulse comes at the cycle the first start predicts.

A separate directed check confirms that every read index arrives in ascending order right up to the last row.

// File: rtl/mcast_flush_pkg.sv
package mcast_flush_pkg;

    // Row field positions that the table decodes
    localparam int ADDR_LO   = 0;
    localparam int ADDR_W    = 48;
    localparam int MC_BIT    = 40;
    localparam int VID_LO    = 48;
    localparam int VID_W     = 12;
    localparam int TYPE_LO   = 60;
    localparam int SUPER_BIT = 65;
    localparam int MASK_LO   = 66;

    typedef enum logic [1:0] {
        ROW_FREE  = 2'd0,
        ROW_ADDR  = 2'd1,
        ROW_VLAN  = 2'd2,
        ROW_VADDR = 2'd3
    } row_kind_e;

    typedef enum logic [1:0] {
        S_IDLE  = 2'd0,
        S_READ  = 2'd1,
        S_CHECK = 2'd2,
        S_FIN   = 2'd3
    } scan_state_e;

endpackage

// File: rtl/mcast_flush_judge.sv
module mcast_flush_judge
    import mcast_flush_pkg::*;
#(
    parameter int PORTS = 3
) (
    input  logic [MASK_LO+PORTS-1:0] row_i,
    input  logic [PORTS-1:0]         flush_mask_i,
    input  logic [VID_W-1:0]         vid_i,
    input  logic                     all_vlan_i,
    output logic                     change_o,
    output logic [MASK_LO+PORTS-1:0] row_o
);
    localparam int ROW_W = MASK_LO + PORTS;

    row_kind_e          kind;
    logic [PORTS-1:0]   members;
    logic [PORTS-1:0]   left;
    logic               kind_ok;
    logic               vlan_ok;
    logic               bcast;

    always_comb begin
        kind    = row_kind_e'(row_i[TYPE_LO +: 2]);
        members = row_i[MASK_LO +: PORTS];
        left    = members & ~flush_mask_i;
        kind_ok = (kind == ROW_ADDR) || (kind == ROW_VADDR);
        vlan_ok = all_vlan_i || (row_i[VID_LO +: VID_W] == vid_i);
        bcast   = &row_i[ADDR_LO +: ADDR_W];

        change_o = kind_ok && vlan_ok && row_i[MC_BIT] && !row_i[SUPER_BIT]
                   && !bcast && (|(members & flush_mask_i));

        row_o = row_i;
        row_o[MASK_LO +: PORTS] = left;
        if (left == '0)
            row_o[TYPE_LO +: 2] = ROW_FREE;
    end

    // Width sanity for the derived row size
    initial begin
        assert (ROW_W > SUPER_BIT) else $error("row too narrow");
    end

endmodule

// File: rtl/mcast_flush_seq.sv
module mcast_flush_seq
    import mcast_flush_pkg::*;
#(
    parameter int PORTS = 3,
    parameter int DEPTH = 12,
    localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic [PORTS-1:0] flush_mask_i,
    input  logic [VID_W-1:0] vid_i,
    input  logic             all_vlan_i,
    input  logic             change_i,
    output logic [PORTS-1:0] mask_q_o,
    output logic [VID_W-1:0] vid_q_o,
    output logic             all_q_o,
    output logic             rd_en_o,
    output logic             wr_en_o,
    output logic [AW-1:0]    addr_o,
    output logic             busy_o,
    output logic             done_o
);
    localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

    scan_state_e state_q, state_d;
    logic [AW-1:0] idx_q;

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE:  if (start_i) state_d = S_READ;
            S_READ:  state_d = S_CHECK;
            S_CHECK: state_d = (idx_q == LAST) ? S_FIN : S_READ;
            S_FIN:   state_d = S_IDLE;
            default: state_d = S_IDLE;
        endcase
    end

    // State register, index and latched parameters
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q  <= S_IDLE;
            idx_q    <= '0;
            mask_q_o <= '0;
            vid_q_o  <= '0;
            all_q_o  <= 1'b0;
        end else begin
            state_q <= state_d;
            if (state_q == S_IDLE && start_i) begin
                idx_q    <= '0;
                mask_q_o <= flush_mask_i;
                vid_q_o  <= vid_i;
                all_q_o  <= all_vlan_i;
            end else if (state_q == S_CHECK && idx_q != LAST) begin
                idx_q <= idx_q + 1'b1;
            end
        end
    end

    // Outputs decoded from state
    always_comb begin
        rd_en_o = 1'b0;
        wr_en_o = 1'b0;
        done_o  = 1'b0;
        busy_o  = 1'b1;
        unique case (state_q)
            S_IDLE:  busy_o  = 1'b0;
            S_READ:  rd_en_o = 1'b1;
            S_CHECK: wr_en_o = change_i;
            S_FIN:   done_o  = 1'b1;
            default: busy_o  = 1'b0;
        endcase
    end
    assign addr_o = idx_q;

    // R2: a read and a write never share a cycle
    p_rd_wr_excl_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !(rd_en_o && wr_en_o));

    // R2: completion is a single-cycle pulse
    p_done_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    // R9: a write-back always follows the read of the same index
    p_wr_after_rd_r9: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en_o |-> ($past(rd_en_o) && $stable(addr_o)));

    // R2: indexes stay inside the table
    p_addr_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en_o |-> (addr_o <= LAST));

    // R11: parameters hold while a scan runs
    p_param_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && $past(busy_o)) |-> ($stable(mask_q_o) && $stable(vid_q_o)));

endmodule

// File: rtl/mcast_flush.sv
module mcast_flush
    import mcast_flush_pkg::*;
#(
    parameter int PORTS = 3,
    parameter int DEPTH = 12,
    localparam int AW    = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int ROW_W = MASK_LO + PORTS
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic [PORTS-1:0] flush_mask_i,
    input  logic [VID_W-1:0] vid_i,
    input  logic             all_vlan_i,
    output logic             tbl_rd_en_o,
    output logic [AW-1:0]    tbl_addr_o,
    input  logic [ROW_W-1:0] tbl_rd_data_i,
    output logic             tbl_wr_en_o,
    output logic [ROW_W-1:0] tbl_wr_data_o,
    output logic             busy_o,
    output logic             done_o
);
    logic [PORTS-1:0] mask_q;
    logic [VID_W-1:0] vid_q;
    logic             all_q;
    logic             change;

    mcast_flush_seq #(.PORTS(PORTS), .DEPTH(DEPTH)) u_seq (
        .clk          (clk),
        .rst_n        (rst_n),
        .start_i      (start_i),
        .flush_mask_i (flush_mask_i),
        .vid_i        (vid_i),
        .all_vlan_i   (all_vlan_i),
        .change_i     (change),
        .mask_q_o     (mask_q),
        .vid_q_o      (vid_q),
        .all_q_o      (all_q),
        .rd_en_o      (tbl_rd_en_o),
        .wr_en_o      (tbl_wr_en_o),
        .addr_o       (tbl_addr_o),
        .busy_o       (busy_o),
        .done_o       (done_o)
    );

    mcast_flush_judge #(.PORTS(PORTS)) u_judge (
        .row_i        (tbl_rd_data_i),
        .flush_mask_i (mask_q),
        .vid_i        (vid_q),
        .all_vlan_i   (all_q),
        .change_o     (change),
        .row_o        (tbl_wr_data_o)
    );

    // R9: no flushed port survives in a written row
    p_flushed_gone_r9: assert property (@(posedge clk) disable iff (!rst_n)
        tbl_wr_en_o |-> ((tbl_wr_data_o[MASK_LO +: PORTS] & mask_q) == '0));

    // R10: a released row carries an empty mask
    p_free_empty_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (tbl_wr_en_o && tbl_wr_data_o[TYPE_LO +: 2] == ROW_FREE)
            |-> (tbl_wr_data_o[MASK_LO +: PORTS] == '0));

    // R6: super rows are never written
    p_super_kept_r6: assert property (@(posedge clk) disable iff (!rst_n)
        tbl_wr_en_o |-> !tbl_rd_data_i[SUPER_BIT]);

    // R7: broadcast rows are never written
    p_bcast_kept_r7: assert property (@(posedge clk) disable iff (!rst_n)
        tbl_wr_en_o |-> !(&tbl_rd_data_i[ADDR_LO +: ADDR_W]));

    // R1: quiet right after reset
    p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o |-> !(tbl_rd_en_o || tbl_wr_en_o));

endmodule

// File: tb/mcast_flush_tb.sv
module mcast_flush_tb;
    localparam int PORTS = 3;
    localparam int DEPTH = 12;
    localparam int AW    = $clog2(DEPTH);
    localparam int ROW_W = 66 + PORTS;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             start = 1'b0;
    logic [PORTS-1:0] fmask = '0;
    logic [11:0]      vid = '0;
    logic             allv = 1'b0;
    logic             rd_en, wr_en, busy, done;
    logic [AW-1:0]    addr;
    logic [ROW_W-1:0] rd_data, wr_data;

    logic [ROW_W-1:0] mem  [DEPTH];
    logic [ROW_W-1:0] init [DEPTH];

    int checks = 0;
    int errors = 0;
    int rd_expect = 0;
    int wr_count = 0;
    int done_count = 0;

    always #10 clk = ~clk;

    mcast_flush #(.PORTS(PORTS), .DEPTH(DEPTH)) u_dut (
        .clk(clk), .rst_n(rst_n), .start_i(start), .flush_mask_i(fmask),
        .vid_i(vid), .all_vlan_i(allv), .tbl_rd_en_o(rd_en), .tbl_addr_o(addr),
        .tbl_rd_data_i(rd_data), .tbl_wr_en_o(wr_en), .tbl_wr_data_o(wr_data),
        .busy_o(busy), .done_o(done)
    );

    // Table model: one-cycle read latency
    always @(posedge clk) begin
        if (rd_en) rd_data <= mem[addr];
        if (wr_en) mem[addr] <= wr_data;
    end

    task automatic check(input bit ok, input string req, input string what,
                         input logic [ROW_W-1:0] act, input logic [ROW_W-1:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // Read order and strobe monitor (R2)
    always @(negedge clk) begin
        if (rst_n) begin
            if (rd_en) begin
                check(int'(addr) == rd_expect, "R2", "read index order",
                      ROW_W'(addr), ROW_W'(rd_expect));
                rd_expect++;
            end
            if (wr_en) wr_count++;
            if (done) done_count++;
        end
    end

    function automatic logic [ROW_W-1:0] mk(input int kind, input int v,
            input logic [47:0] mac, input bit sup, input logic [PORTS-1:0] m);
        logic [ROW_W-1:0] r = '0;
        r[47:0]  = mac;
        r[59:48] = 12'(v);
        r[61:60] = 2'(kind);
        r[65]    = sup;
        r[66 +: PORTS] = m;
        return r;
    endfunction

    // Requirement that decides a row's outcome
    function automatic string cause(input logic [ROW_W-1:0] r, input logic [PORTS-1:0] fm,
                                    input logic [11:0] v, input bit a);
        logic [PORTS-1:0] m = r[66 +: PORTS];
        if (!(r[61:60] == 2'd1 || r[61:60] == 2'd3)) return "R3";
        if (!a && r[59:48] != v) return "R4";
        if (!r[40]) return "R5";
        if (r[65]) return "R6";
        if (r[47:0] == 48'hFFFF_FFFF_FFFF) return "R7";
        if ((m & fm) == '0) return "R8";
        if ((m & ~fm) == '0) return "R10";
        return "R9";
    endfunction

    function automatic logic [ROW_W-1:0] expect_row(input logic [ROW_W-1:0] r,
            input logic [PORTS-1:0] fm, input logic [11:0] v, input bit a);
        logic [ROW_W-1:0] e = r;
        string c = cause(r, fm, v, a);
        if (c == "R9") e[66 +: PORTS] = r[66 +: PORTS] & ~fm;
        if (c == "R10") begin
            e[66 +: PORTS] = '0;
            e[61:60] = 2'd0;
        end
        return e;
    endfunction

    task automatic load_table();
        init[0]  = mk(1, 0, 48'h01005E000001, 0, 3'b011);
        init[1]  = mk(3, 5, 48'h01005E000002, 0, 3'b001);
        init[2]  = mk(2, 5, 48'h010000000000, 0, 3'b111);
        init[3]  = mk(0, 0, 48'h01005E000001, 0, 3'b111);
        init[4]  = mk(1, 0, 48'h001122334455, 0, 3'b001);
        init[5]  = mk(1, 0, 48'h01005E000003, 1, 3'b001);
        init[6]  = mk(3, 5, 48'hFFFFFFFFFFFF, 0, 3'b001);
        init[7]  = mk(1, 0, 48'h01005E000002, 0, 3'b100);
        init[8]  = mk(3, 7, 48'h01005E000001, 0, 3'b101);
        init[9]  = mk(3, 5, 48'h01005E000003, 0, 3'b011);
        init[10] = mk(3, 7, 48'h01005E000002, 0, 3'b001);
        init[11] = mk(1, 0, 48'h01005E000004, 0, 3'b111);
        for (int i = 0; i < DEPTH; i++) mem[i] = init[i];
    endtask

    // Start a scan; optionally fire a second start mid-scan (R11)
    task automatic run_scan(input logic [PORTS-1:0] fm, input logic [11:0] v,
                            input bit a, input bit poke);
        int cyc = 0;
        int seen_at = -1;
        int exp_writes = 0;
        load_table();
        rd_expect = 0;
        wr_count = 0;
        done_count = 0;
        @(negedge clk);
        fmask = fm; vid = v; allv = a; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        fmask = '0; vid = '0; allv = 1'b0;
        cyc = 1;
        while (cyc < 2 * DEPTH + 6) begin
            if (done && seen_at < 0) seen_at = cyc;
            if (poke && cyc == 9) begin
                fmask = 3'b010; vid = 12'd7; allv = 1'b0; start = 1'b1;
            end else if (poke && cyc == 2 * DEPTH + 1) begin
                fmask = 3'b111; allv = 1'b1; start = 1'b1;
            end else begin
                start = 1'b0;
            end
            @(negedge clk);
            cyc++;
        end
        start = 1'b0;
        check(seen_at == 2 * DEPTH + 1, "R2", "done cycle",
              ROW_W'(seen_at), ROW_W'(2 * DEPTH + 1));
        check(rd_expect == DEPTH, "R2", "read count", ROW_W'(rd_expect), ROW_W'(DEPTH));
        check(!busy, "R2", "busy after done", ROW_W'(busy), '0);
        check(done_count == 1, poke ? "R11" : "R2", "done pulse count",
              ROW_W'(done_count), ROW_W'(1));
        for (int i = 0; i < DEPTH; i++) begin
            string c = cause(init[i], fm, v, a);
            logic [ROW_W-1:0] e = expect_row(init[i], fm, v, a);
            if (e != init[i]) exp_writes++;
            check(mem[i] == e, poke ? "R11" : c, $sformatf("row %0d", i), mem[i], e);
        end
        check(wr_count == exp_writes, "R8", "write count",
              ROW_W'(wr_count), ROW_W'(exp_writes));
    endtask

    task automatic t_reset();
        @(negedge clk);
        check(!done && !busy && !rd_en && !wr_en, "R1", "idle outputs",
              ROW_W'({done, busy, rd_en, wr_en}), '0);
    endtask

    task automatic t_all_vlans();
        run_scan(3'b001, 12'd0, 1'b1, 1'b0);
    endtask

    task automatic t_one_vlan();
        run_scan(3'b011, 12'd5, 1'b0, 1'b0);
    endtask

    task automatic t_start_while_busy();
        run_scan(3'b101, 12'd0, 1'b1, 1'b1);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        rd_data = '0;
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        t_reset();
        t_all_vlans();
        t_one_vlan();
        t_start_while_busy();
        repeat (4) @(negedge clk);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule